// File: doc/BRIEF.md
# Reset and Interrupt Instruction Injector

This block sits in the fetch path of a small single-cycle processor, between the instruction memory read port and the instruction decoder. In normal running it hands the fetched word to the decoder untouched. When the processor must be started or diverted, it substitutes fixed instruction words instead, so the ordinary datapath does the work of entering reset or an interrupt. No dedicated vector logic is needed in the datapath.

A two-bit state register selects one of four sources for the decoder. Source 0 is the memory word. Sources 1 and 2 are a two-word start-up sequence. The first word loads the stack pointer (r13) from address 0, formed as r0 minus r0. The second loads the program counter (r15) from the word addressed through r15. Source 3 is a single branch-and-link used as the interrupt entry. While reset is high, the block also asks the program counter to clear to zero on the next clock edge.

The three injected words are parameters. Their defaults are the always-execute encodings of the three instructions.

Top module: `inj_injector_top`

## Requirements
- R1: In state 00 (normal running) `instr_o` equals `imem_data_i` in the same cycle, for any memory word.
- R2: From state 00, `rst_i` high at a clock edge moves the state to 01, whatever the value of `irq_i`.
- R3: State 01 always moves to 10 at the next edge, and state 10 always moves to 00, whatever `rst_i` and `irq_i` are.
- R4: From state 00, `rst_i` low and `irq_i` high at a clock edge moves the state to 11.
- R5: State 11 moves to 00 at the next edge, whatever `rst_i` and `irq_i` are. A reset that arrives during state 11 is therefore taken one cycle later, from state 00.
- R6: From state 00, `rst_i` low and `irq_i` low at a clock edge keep the state at 00.
- R7: In state 01 `instr_o` is 32'hE710D000, which is the load of r13 from [r0, -r0].
- R8: In state 10 `instr_o` is 32'hE59FF000, which is the load of r15 from [r15].
- R9: In state 11 `instr_o` is 32'hEB000002, a branch-and-link whose 24-bit offset field is 2 (8 bytes).
- R10: `pc_clear_o` is high in exactly the cycles in which `rst_i` is high.
- R11: After power-up, before the first clock edge, the state is 00.
- R12: If `irq_i` stays high, the interrupt is taken again each time the state returns to 00, which gives the pattern 11, 00, 11, 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous processor reset, active high; starts the start-up sequence |
| irq_i | input | 1 | Synchronous level-sensitive interrupt request, active high |
| imem_data_i | input | 32 | Word read from instruction memory |
| instr_o | output | 32 | Instruction word presented to the decoder |
| state_o | output | 2 | Current injector state, which is also the source select |
| pc_clear_o | output | 1 | Request to clear the program counter on the next edge |

## Verification
The bench uses the default data width and the default injected encodings. Every cycle it can therefore compare `instr_o` against the three literal words given in the requirements.

With the parameters at these values, each of the four states is reachable from the bench using only the input pins. The bench drives every row of the transition table, including these cases:
- reset and interrupt raised together;
- reset held over several cycles;
- reset arriving during the interrupt state;
- an interrupt held high so that it retriggers.

// File: rtl/inj_pkg.sv
package inj_pkg;

  typedef enum logic [1:0] {
    ST_RUN    = 2'b00,
    ST_RST_SP = 2'b01,
    ST_RST_PC = 2'b10,
    ST_IRQ    = 2'b11
  } inj_state_e;

  localparam int unsigned ST_W      = 2;
  localparam int unsigned N_SOURCES = 4;

  // Always-execute encodings used as defaults.
  localparam logic [31:0] DEF_WORD_SP  = 32'hE710D000; // ldr r13,[r0,-r0]
  localparam logic [31:0] DEF_WORD_PC  = 32'hE59FF000; // ldr r15,[r15]
  localparam logic [31:0] DEF_WORD_IRQ = 32'hEB000002; // bl, offset field 2

endpackage

// File: rtl/inj_next_state.sv
module inj_next_state
  import inj_pkg::*;
(
  input  inj_state_e cur_i,
  input  logic       rst_i,
  input  logic       irq_i,
  output inj_state_e nxt_o
);

  always_comb begin
    nxt_o = ST_RUN;
    unique case (cur_i)
      ST_RUN: begin
        if (rst_i)      nxt_o = ST_RST_SP;
        else if (irq_i) nxt_o = ST_IRQ;
        else            nxt_o = ST_RUN;
      end
      ST_RST_SP: nxt_o = ST_RST_PC;
      ST_RST_PC: nxt_o = ST_RUN;
      ST_IRQ:    nxt_o = ST_RUN;
      default:   nxt_o = ST_RUN;
    endcase
  end

endmodule

// File: rtl/inj_word_mux.sv
module inj_word_mux
  import inj_pkg::*;
#(
  parameter int unsigned            DATA_W   = 32,
  parameter logic [DATA_W-1:0]      WORD_SP  = DATA_W'(DEF_WORD_SP),
  parameter logic [DATA_W-1:0]      WORD_PC  = DATA_W'(DEF_WORD_PC),
  parameter logic [DATA_W-1:0]      WORD_IRQ = DATA_W'(DEF_WORD_IRQ)
) (
  input  logic [ST_W-1:0]   sel_i,
  input  logic [DATA_W-1:0] mem_i,
  output logic [DATA_W-1:0] word_o
);

  logic [DATA_W-1:0] src [N_SOURCES];

  genvar g;
  generate
    for (g = 0; g < N_SOURCES; g++) begin : g_src
      if (g == 0) begin : g_mem
        assign src[g] = mem_i;
      end else if (g == 1) begin : g_sp
        assign src[g] = WORD_SP;
      end else if (g == 2) begin : g_pc
        assign src[g] = WORD_PC;
      end else begin : g_irq
        assign src[g] = WORD_IRQ;
      end
    end
  endgenerate

  assign word_o = src[sel_i];

endmodule

// File: rtl/inj_injector_top.sv
module inj_injector_top
  import inj_pkg::*;
#(
  parameter int unsigned       DATA_W   = 32,
  parameter logic [DATA_W-1:0] WORD_SP  = DATA_W'(DEF_WORD_SP),
  parameter logic [DATA_W-1:0] WORD_PC  = DATA_W'(DEF_WORD_PC),
  parameter logic [DATA_W-1:0] WORD_IRQ = DATA_W'(DEF_WORD_IRQ)
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              irq_i,
  input  logic [DATA_W-1:0] imem_data_i,
  output logic [DATA_W-1:0] instr_o,
  output logic [ST_W-1:0]   state_o,
  output logic              pc_clear_o
);

  // Power-up value of the state register; rst_i is a functional input.
  inj_state_e state_q = ST_RUN;
  inj_state_e state_d;

  inj_next_state u_next (
    .cur_i (state_q),
    .rst_i (rst_i),
    .irq_i (irq_i),
    .nxt_o (state_d)
  );

  always_ff @(posedge clk_i) begin
    state_q <= state_d;
  end

  inj_word_mux #(
    .DATA_W   (DATA_W),
    .WORD_SP  (WORD_SP),
    .WORD_PC  (WORD_PC),
    .WORD_IRQ (WORD_IRQ)
  ) u_mux (
    .sel_i  (state_q),
    .mem_i  (imem_data_i),
    .word_o (instr_o)
  );

  assign state_o    = state_q;
  assign pc_clear_o = rst_i;

  // Assertions guarding the state sequence and the pass-through path.
  logic started_q = 1'b0;
  always_ff @(posedge clk_i) started_q <= 1'b1;

  always_comb begin
    if (started_q && state_q == ST_RUN)
      assert_pass_through_R1: assert (instr_o == imem_data_i);
  end

  assert_reset_entry_R2: assert property (@(posedge clk_i) disable iff (!started_q)
    (state_q == ST_RUN && rst_i) |=> (state_q == ST_RST_SP));

  assert_sp_to_pc_R3: assert property (@(posedge clk_i) disable iff (!started_q)
    (state_q == ST_RST_SP) |=> (state_q == ST_RST_PC));

  assert_pc_to_run_R3: assert property (@(posedge clk_i) disable iff (!started_q)
    (state_q == ST_RST_PC) |=> (state_q == ST_RUN));

  assert_irq_entry_R4: assert property (@(posedge clk_i) disable iff (!started_q)
    (state_q == ST_RUN && !rst_i && irq_i) |=> (state_q == ST_IRQ));

  assert_irq_exit_R5: assert property (@(posedge clk_i) disable iff (!started_q)
    (state_q == ST_IRQ) |=> (state_q == ST_RUN));

  assert_idle_hold_R6: assert property (@(posedge clk_i) disable iff (!started_q)
    (state_q == ST_RUN && !rst_i && !irq_i) |=> (state_q == ST_RUN));

endmodule

// File: tb/inj_injector_top_tb.sv
module inj_injector_top_tb_top;

  localparam int CLK_HALF = 4; // 125 MHz

  logic        clk = 1'b0;
  logic        rst = 1'b0;
  logic        irq = 1'b0;
  logic [31:0] mem = 32'h0;
  logic [31:0] instr;
  logic [1:0]  state;
  logic        pc_clr;

  int errors = 0;
  int checks = 0;
  int exp_st = 0;
  bit done   = 1'b0;

  always #CLK_HALF clk = ~clk;

  inj_injector_top dut_i (
    .clk_i       (clk),
    .rst_i       (rst),
    .irq_i       (irq),
    .imem_data_i (mem),
    .instr_o     (instr),
    .state_o     (state),
    .pc_clear_o  (pc_clr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int model_next(input int s, input bit r, input bit i);
    if (s == 0) return r ? 1 : (i ? 3 : 0);
    if (s == 1) return 2;
    return 0;
  endfunction

  function automatic logic [31:0] model_word(input int s, input logic [31:0] m);
    case (s)
      1: return 32'hE710D000;
      2: return 32'hE59FF000;
      3: return 32'hEB000002;
      default: return m;
    endcase
  endfunction

  function automatic string st_tag(input int prev, input bit r, input bit i);
    if (prev == 0) return r ? "R2" : (i ? "R4" : "R6");
    if (prev == 3) return "R5";
    return "R3";
  endfunction

  function automatic string word_tag(input int s);
    case (s)
      1: return "R7";
      2: return "R8";
      3: return "R9";
      default: return "R1";
    endcase
  endfunction

  string last_tag = "R11";

  // Drive inputs after the falling edge, compare outputs, then advance the model.
  task automatic cyc(input bit r, input bit i, input logic [31:0] m);
    @(negedge clk);
    rst = r; irq = i; mem = m;
    #1;
    check(last_tag, 32'(state), 32'(exp_st));
    check(word_tag(exp_st), instr, model_word(exp_st, m));
    check("R10", 32'(pc_clr), 32'(r));
    @(posedge clk);
    last_tag = st_tag(exp_st, r, i);
    exp_st = model_next(exp_st, r, i);
  endtask

  initial begin
    #1;
    check("R11", 32'(state), 32'd0);
    // R1 R6: idle with varied memory words
    cyc(0, 0, 32'h12345678);
    cyc(0, 0, 32'hFFFFFFFF);
    cyc(0, 0, 32'h00000000);
    // R2 R3 R7 R8: reset together with interrupt
    cyc(1, 1, 32'hA5A5A5A5);
    cyc(0, 1, 32'h5A5A5A5A);
    cyc(1, 1, 32'h11111111);
    cyc(0, 0, 32'h22222222);
    // reset held several cycles
    for (int k = 0; k < 7; k++) cyc(1, 0, 32'h30000000 + k);
    cyc(0, 0, 32'hDEADBEEF);
    cyc(0, 0, 32'hCAFEF00D);
    // R4 R5 R9: single interrupt pulse
    cyc(0, 1, 32'h0BADF00D);
    cyc(0, 0, 32'h44444444);
    cyc(0, 0, 32'h55555555);
    // R12: interrupt held high retriggers
    for (int k = 0; k < 6; k++) cyc(0, 1, 32'h60000000 + k);
    // R5: reset arriving during interrupt state
    cyc(0, 0, 32'h77777777);
    cyc(0, 1, 32'h88888888);
    cyc(1, 0, 32'h99999999);
    cyc(1, 0, 32'hAAAAAAAA);
    cyc(0, 0, 32'hBBBBBBBB);
    cyc(0, 0, 32'hCCCCCCCC);
    cyc(0, 0, 32'hDDDDDDDD);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(2 * CLK_HALF * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule